// File: doc/BRIEF.md
# APB Master with Two-Target Address Decode

This block turns a plain command port into APB accesses. A level-sensitive request input, a read/not-write select, a 9-bit address and an 8-bit write value go in. The block runs the two-phase APB handshake on a shared bus that has one select line for each of two targets. Address bit 8 picks the target. The block returns the read value, a completion strobe and the error response of the target that answered.

The command is captured when an access begins and is held on the bus until the access ends. Software-facing logic can therefore change the command inputs while an access is still running. If the request stays high when an access completes, the next access begins straight away with a new setup cycle. If the request is low, the bus goes idle.

Top module: `apb_dual_target_master`

## Requirements
- R1: While reset is asserted (`rst_n` low) and directly after it, both selects, `penable` and `done` are low and `rd_data` reads 0.
- R2: `paddr[8]` = 0 asserts only `psel_a`, and `paddr[8]` = 1 asserts only `psel_b`. The two selects are never high together.
- R3: Each access opens with one setup cycle. In that cycle the select is high, `penable` is low, and `paddr` and `pwdata` carry the captured command.
- R4: `pwrite` is the inverse of the captured `rd_nwr`: a command of 1 (read) drives `pwrite` = 0, and a command of 0 (write) drives `pwrite` = 1.
- R5: The cycle after setup raises `penable`. `penable` and the select stay high until a cycle in which the selected target's ready is high.
- R6: While `xfer_en` is low and no access is in flight, both selects and `penable` stay low.
- R7: When a read completes, `rd_data` takes the selected target's read data. A completed write leaves `rd_data` unchanged.
- R8: `done` is high for exactly one cycle, the cycle after the completing enable cycle. `err` equals the selected target's `pslverr` sampled in that completing cycle.
- R9: If `xfer_en` is high when an access completes, the next cycle is a setup cycle for the command present at that moment. Otherwise the bus goes idle.
- R10: `paddr`, `pwrite` and `pwdata` stay stable from setup until completion, even when the command inputs change during the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| xfer_en | input | 1 | Level request to run accesses |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | 9 | Command address |
| cmd_wdata | input | 8 | Command write value |
| paddr | output | 9 | Bus address |
| pwrite | output | 1 | Bus direction, 1 = write |
| pwdata | output | 8 | Bus write data |
| penable | output | 1 | Enable phase marker |
| psel_a | output | 1 | Select for target A (address bit 8 = 0) |
| psel_b | output | 1 | Select for target B (address bit 8 = 1) |
| prdata_a | input | 8 | Read data from target A |
| prdata_b | input | 8 | Read data from target B |
| pready_a | input | 1 | Ready from target A |
| pready_b | input | 1 | Ready from target B |
| pslverr_a | input | 1 | Error from target A |
| pslverr_b | input | 1 | Error from target B |
| rd_data | output | 8 | Captured read value |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Error of the completed access |

## Verification
The hardest case to reach is the chained access. Here the request stays high through completion, and a new command has to be picked up on the very edge that ends the previous one, which gives setup with no idle cycle in between. The bench holds `xfer_en` high and changes the command inputs in the same half-cycle in which it sees ready. Straight after that edge it checks the other target's select and the new address. Wait states are set for each vector in the bench's two register-file targets. Those targets also flag an error on one address, so stalled enable phases, command changes in the middle of an access and error returns from both targets all occur.

// File: rtl/apb_dual_target_master.sv
module apb_dual_target_master #(
  parameter int AW      = 9,
  parameter int DW      = 8,
  parameter int SEL_BIT = AW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xfer_en,
  input  logic          rd_nwr,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic [AW-1:0] paddr,
  output logic          pwrite,
  output logic [DW-1:0] pwdata,
  output logic          penable,
  output logic          psel_a,
  output logic          psel_b,
  input  logic [DW-1:0] prdata_a,
  input  logic [DW-1:0] prdata_b,
  input  logic          pready_a,
  input  logic          pready_b,
  input  logic          pslverr_a,
  input  logic          pslverr_b,
  output logic [DW-1:0] rd_data,
  output logic          done,
  output logic          err
);

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_ACCESS} st_t;
  st_t state;

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          rd_q;

  wire hi_tgt = addr_q[SEL_BIT];
  wire on_bus = (state != ST_IDLE);
  wire rdy    = hi_tgt ? pready_b : pready_a;
  wire finish = (state == ST_ACCESS) && rdy;
  wire launch = xfer_en && ((state == ST_IDLE) || finish);

  assign psel_a  = on_bus && !hi_tgt;
  assign psel_b  = on_bus && hi_tgt;
  assign penable = (state == ST_ACCESS);
  assign paddr   = addr_q;
  assign pwdata  = wdata_q;
  assign pwrite  = !rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:   if (xfer_en) state <= ST_SETUP;
        ST_SETUP:  state <= ST_ACCESS;
        ST_ACCESS: if (rdy) state <= xfer_en ? ST_SETUP : ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rd_q    <= 1'b1;
    end else if (launch) begin
      addr_q  <= cmd_addr;
      wdata_q <= cmd_wdata;
      rd_q    <= rd_nwr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= finish;
      err  <= finish && (hi_tgt ? pslverr_b : pslverr_a);
      if (finish && rd_q) rd_data <= hi_tgt ? prdata_b : prdata_a;
    end
  end

  // R2
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(psel_a && psel_b));

  // R3
  setup_then_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((psel_a || psel_b) && !penable) |=> (penable && (psel_a || psel_b)));

  // R5
  hold_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (penable && !(psel_a ? pready_a : pready_b)) |=> (penable && $stable(psel_a) && $stable(psel_b)));

  // R10
  stable_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel_a || psel_b) && !(penable && (psel_a ? pready_a : pready_b))
      |=> ($stable(paddr) && $stable(pwrite) && $stable(pwdata)));

  // R6
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_en && !psel_a && !psel_b) |=> (!psel_a && !psel_b && !penable));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (penable && (psel_a ? pready_a : pready_b)) |=> done);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done || $past(penable));

endmodule

// File: tb/apb_dual_target_master_bench.sv
module apb_dual_target_master_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic xfer_en = 0, rd_nwr = 0;
  logic [8:0] cmd_addr = '0;
  logic [7:0] cmd_wdata = '0;
  logic [8:0] paddr;
  logic pwrite, penable, psel_a, psel_b;
  logic [7:0] pwdata, prdata_a, prdata_b, rd_data;
  logic pready_a, pready_b, pslverr_a, pslverr_b, done, err;

  int n_run = 0, n_fail = 0, cycles = 0, wait_n = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  apb_dual_target_master u_apb_dual_target_master (
    .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en), .rd_nwr(rd_nwr),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .paddr(paddr), .pwrite(pwrite),
    .pwdata(pwdata), .penable(penable), .psel_a(psel_a), .psel_b(psel_b),
    .prdata_a(prdata_a), .prdata_b(prdata_b), .pready_a(pready_a), .pready_b(pready_b),
    .pslverr_a(pslverr_a), .pslverr_b(pslverr_b), .rd_data(rd_data), .done(done), .err(err));

  // two register-file targets with bench-set wait states; low byte 8'hEE answers with an error
  logic [7:0] mem_a [256];
  logic [7:0] mem_b [256];
  int cnt_a = 0, cnt_b = 0;
  assign pready_a  = psel_a && penable && (cnt_a >= wait_n);
  assign pready_b  = psel_b && penable && (cnt_b >= wait_n);
  assign prdata_a  = mem_a[paddr[7:0]];
  assign prdata_b  = mem_b[paddr[7:0]];
  assign pslverr_a = pready_a && (paddr[7:0] == 8'hEE);
  assign pslverr_b = pready_b && (paddr[7:0] == 8'hEE);

  initial for (int i = 0; i < 256; i++) begin mem_a[i] = 8'h00; mem_b[i] = 8'h00; end

  always @(posedge clk) begin
    cnt_a <= (psel_a && penable && !pready_a) ? cnt_a + 1 : 0;
    cnt_b <= (psel_b && penable && !pready_b) ? cnt_b + 1 : 0;
    if (pready_a && pwrite && !pslverr_a) mem_a[paddr[7:0]] <= pwdata;
    if (pready_b && pwrite && !pslverr_b) mem_b[paddr[7:0]] <= pwdata;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      summary();
    end
  end

  // one access with xfer_en dropped after setup; returns after the done cycle is checked
  task automatic access(input bit rd, input logic [8:0] a, input logic [7:0] wd,
                        input logic [7:0] exp_rd, input bit exp_err);
    logic [7:0] prev = rd_data;
    int guard = 0;
    @(negedge clk);
    xfer_en = 1; rd_nwr = rd; cmd_addr = a; cmd_wdata = wd;
    @(negedge clk);
    chk(psel_a == !a[8] && psel_b == a[8], "R2", "select", {psel_b, psel_a}, {a[8], !a[8]});
    chk(!penable && paddr == a, "R3", "setup addr", paddr, a);
    if (!rd) chk(pwdata == wd, "R3", "setup wdata", pwdata, wd);
    chk(pwrite == !rd, "R4", "pwrite", pwrite, !rd);
    xfer_en = 0; rd_nwr = !rd; cmd_addr = ~a; cmd_wdata = ~wd;
    @(negedge clk);
    chk(penable == 1, "R5", "enable after setup", penable, 1);
    while (!(pready_a || pready_b) && guard < 20) begin
      @(negedge clk); guard++;
      chk(penable && (psel_a || psel_b), "R5", "enable held", penable, 1);
    end
    chk(paddr == a && pwrite == !rd, "R10", "held addr", paddr, a);
    @(negedge clk);
    chk(done == 1, "R8", "done", done, 1);
    chk(err == exp_err, "R8", "err", err, exp_err);
    chk(rd_data == (rd ? exp_rd : prev), "R7", "rd_data", rd_data, rd ? exp_rd : prev);
    chk(!psel_a && !psel_b, "R9", "idle after", {psel_b, psel_a}, 0);
    @(negedge clk);
    chk(done == 0, "R8", "done single", done, 0);
  endtask

  // {rd, addr, wdata, exp_rd, exp_err, waits}
  localparam logic [28:0] VEC [9] = '{
    {1'b0, 9'h005, 8'hA5, 8'h00, 1'b0, 2'd0},
    {1'b0, 9'h105, 8'h3C, 8'h00, 1'b0, 2'd1},
    {1'b1, 9'h005, 8'h00, 8'hA5, 1'b0, 2'd2},
    {1'b1, 9'h105, 8'h00, 8'h3C, 1'b0, 2'd0},
    {1'b0, 9'h0EE, 8'h77, 8'h00, 1'b1, 2'd0},
    {1'b1, 9'h1EE, 8'h00, 8'h00, 1'b1, 2'd2},
    {1'b0, 9'h1FF, 8'h5A, 8'h00, 1'b0, 2'd3},
    {1'b1, 9'h1FF, 8'h00, 8'h5A, 1'b0, 2'd1},
    {1'b1, 9'h0FF, 8'h00, 8'h00, 1'b0, 2'd0}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!psel_a && !psel_b && !penable && !done && rd_data == 0, "R1", "reset state",
        {psel_b, psel_a, penable, done}, 0);
    rst_n = 1;
    repeat (4) begin
      @(negedge clk);
      chk(!psel_a && !psel_b && !penable, "R6", "idle bus", {psel_b, psel_a, penable}, 0);
    end

    foreach (VEC[i]) begin
      wait_n = int'(VEC[i][1:0]);
      access(VEC[i][28], VEC[i][27:19], VEC[i][18:11], VEC[i][10:3], VEC[i][2]);
    end

    // R9 chained accesses: keep xfer_en high, swap command on the completing cycle
    wait_n = 1;
    @(negedge clk);
    xfer_en = 1; rd_nwr = 0; cmd_addr = 9'h010; cmd_wdata = 8'h11;
    @(negedge clk);
    @(negedge clk);
    while (!(pready_a || pready_b)) @(negedge clk);
    rd_nwr = 0; cmd_addr = 9'h110; cmd_wdata = 8'h22;
    @(negedge clk);
    chk(done == 1, "R8", "done chained", done, 1);
    chk(psel_b && !psel_a && !penable, "R9", "chained setup", {psel_b, psel_a, penable}, 3'b100);
    chk(paddr == 9'h110 && pwdata == 8'h22, "R9", "chained addr", paddr, 9'h110);
    xfer_en = 0;
    while (!done) @(negedge clk);
    wait_n = 0;
    access(1'b1, 9'h110, 8'h00, 8'h22, 1'b0);
    access(1'b1, 9'h010, 8'h00, 8'h11, 1'b0);

    // R1 reset in the middle of an access
    wait_n = 3;
    @(negedge clk);
    xfer_en = 1; rd_nwr = 1; cmd_addr = 9'h005;
    repeat (3) @(negedge clk);
    rst_n = 0;
    #1;
    chk(!psel_a && !psel_b && !penable && rd_data == 0, "R1", "mid reset", {psel_b, psel_a, penable}, 0);
    xfer_en = 0;
    @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!psel_a && !psel_b && !done, "R6", "idle after reset", {psel_b, psel_a, done}, 0);

    summary();
  end
endmodule